// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the eight-bit status byte of a small 8-bit processor core. Four of its bits are arithmetic condition flags: carry, half carry, zero and overflow. It computes them from the operands, the carry-in, the result and the operation class that the ALU presents. Two more bits track power state. A power-down flag records that the core entered its halt state. A time-out flag records that the watchdog expired. Only the power-up reset, the watchdog and the decoded halt and clear-watchdog instructions touch these two flags. The top two bits are hard-wired to zero.

Software can load the four condition flags with a direct write. The ALU updates them when its flag-update enable is high. The block never saves itself on interrupt entry: firmware that needs the flags preserved has to copy the byte itself. The operand width is a parameter. The status byte stays eight bits, and the half-carry nibble is half the operand width.

Top module: `stat_flag_reg`

## Requirements
- R1: While `por_n` is low, `status` reads 8'h00. The reset is asynchronous.
- R2: An add (`op_kind` = 0) with `flag_en` high computes a + b + `carry_in`. It sets bit 0 (carry) to the carry out of the full width and bit 1 (half carry) to the carry out of the low nibble.
- R3: A subtract (`op_kind` = 1) computes a + ~b + `carry_in`, so a plain subtract passes `carry_in` = 1. Bit 0 is 1 exactly when no borrow occurs, that is when a >= b + (1 - `carry_in`). Bit 1 is 1 exactly when the low nibble of a >= the low nibble of b + (1 - `carry_in`).
- R4: For add and subtract, bit 3 (overflow) is 1 exactly when the signed two's-complement result falls outside the signed range of the operand width.
- R5: For add, subtract and logic (`op_kind` = 2), bit 2 (zero) is 1 exactly when `result` is zero.
- R6: A logic operation leaves bits 0, 1 and 3 unchanged.
- R7: A rotate left through carry (`op_kind` = 3) loads bit 0 from the operand's MSB. A rotate right through carry (`op_kind` = 4) loads it from the operand's LSB. Bits 1 to 3 stay unchanged.
- R8: With `flag_en` and `sw_wr` both low, bits 0 to 3 keep their value. Codes 5 to 7 of `op_kind` change nothing.
- R9: `sw_wr` loads bits 0 to 3 from `sw_data[3:0]` and takes precedence over an ALU update in the same cycle. Bits 4 to 7 of `sw_data` have no effect.
- R10: Bit 4 (power-down) is set by `halt_op` and cleared by `clrwdt_op`; `halt_op` wins if both are high. It is unaffected by software writes and by ALU activity.
- R11: Bit 5 (time-out) is set by `wdt_expire` and cleared by `clrwdt_op` or `halt_op`; `wdt_expire` wins if they coincide. It is unaffected by software writes and by ALU activity.
- R12: Bits 6 and 7 of `status` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| op_kind | input | 3 | Operation class: 0 add, 1 subtract, 2 logic, 3 rotate left through carry, 4 rotate right through carry |
| op_a | input | DATA_W | First ALU operand |
| op_b | input | DATA_W | Second ALU operand |
| carry_in | input | 1 | Carry-in used by add and subtract |
| result | input | DATA_W | ALU result, used for the zero flag |
| flag_en | input | 1 | Apply the ALU flag update this cycle |
| sw_wr | input | 1 | Software write of the condition flags |
| sw_data | input | 8 | Software write data |
| wdt_expire | input | 1 | Watchdog time-out pulse |
| clrwdt_op | input | 1 | Decoded clear-watchdog instruction pulse |
| halt_op | input | 1 | Decoded halt instruction pulse |
| status | output | 8 | Status byte |

## Verification
Two collisions matter most. The watchdog can expire in the same cycle that a halt or clear-watchdog instruction retires. A software write can also land in the same cycle as a flag-updating ALU operation. Directed steps drive each pair together on one clock edge. Random traffic also raises all of these pulses independently, so they overlap often. The bench's behavioural model applies the stated precedence: time-out set beats clear, halt beats clear-watchdog for power-down, and the write beats the ALU. Every mismatch in the status byte on the following cycle is reported.

// File: rtl/stat_flag_pkg.sv
package stat_flag_pkg;

   typedef enum logic [2:0] {
      OPK_ADD   = 3'd0,
      OPK_SUB   = 3'd1,
      OPK_LOGIC = 3'd2,
      OPK_RLC   = 3'd3,
      OPK_RRC   = 3'd4
   } op_kind_e;

   // Bit positions inside the status byte (software decodes these)
   localparam int unsigned BIT_C  = 0;
   localparam int unsigned BIT_AC = 1;
   localparam int unsigned BIT_Z  = 2;
   localparam int unsigned BIT_OV = 3;
   localparam int unsigned BIT_PD = 4;
   localparam int unsigned BIT_TO = 5;
   localparam int unsigned STATUS_W = 8;

   typedef struct packed {
      logic ov;
      logic z;
      logic ac;
      logic c;
   } arith_flags_t;

endpackage

// File: rtl/stat_flag_arith.sv
module stat_flag_arith
   import stat_flag_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter bit          OV_FROM_SIGNS = 1'b0
) (
   input  logic [2:0]        op_kind,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] result,
   output arith_flags_t      flags_nxt,
   output arith_flags_t      flags_mask
);

   localparam int unsigned HALF = DATA_W / 2;
   localparam int unsigned MSB  = DATA_W - 1;

   op_kind_e            kind;
   logic [DATA_W-1:0]   b_eff;
   logic [HALF:0]       nib_sum;
   logic [DATA_W:0]     full_sum;
   logic                ov_bit;

   always_comb begin
      kind     = op_kind_e'(op_kind);
      b_eff    = (kind == OPK_SUB) ? ~op_b : op_b;
      nib_sum  = {1'b0, op_a[HALF-1:0]} + {1'b0, b_eff[HALF-1:0]}
               + {{HALF{1'b0}}, carry_in};
      full_sum = {1'b0, op_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, carry_in};
   end

   generate
      if (OV_FROM_SIGNS) begin : g_ov_sign
         always_comb
            ov_bit = (op_a[MSB] == b_eff[MSB]) && (full_sum[MSB] != op_a[MSB]);
      end else begin : g_ov_carry
         logic [DATA_W-1:0] below_msb;
         always_comb begin
            below_msb = {1'b0, op_a[MSB-1:0]} + {1'b0, b_eff[MSB-1:0]}
                      + {{(DATA_W-1){1'b0}}, carry_in};
            ov_bit    = below_msb[MSB] ^ full_sum[DATA_W];
         end
      end
   endgenerate

   always_comb begin
      flags_nxt  = '0;
      flags_mask = '0;
      unique case (kind)
         OPK_ADD, OPK_SUB: begin
            flags_nxt.c  = full_sum[DATA_W];
            flags_nxt.ac = nib_sum[HALF];
            flags_nxt.ov = ov_bit;
            flags_nxt.z  = (result == '0);
            flags_mask   = '1;
         end
         OPK_LOGIC: begin
            flags_nxt.z  = (result == '0);
            flags_mask.z = 1'b1;
         end
         OPK_RLC: begin
            flags_nxt.c  = op_a[MSB];
            flags_mask.c = 1'b1;
         end
         OPK_RRC: begin
            flags_nxt.c  = op_a[0];
            flags_mask.c = 1'b1;
         end
         default: begin
            flags_nxt  = '0;
            flags_mask = '0;
         end
      endcase
   end

endmodule

// File: rtl/stat_flag_power.sv
module stat_flag_power (
   input  logic clk,
   input  logic por_n,
   input  logic wdt_expire,
   input  logic clrwdt_op,
   input  logic halt_op,
   output logic pd_flag,
   output logic to_flag
);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         pd_flag <= 1'b0;
         to_flag <= 1'b0;
      end else begin
         if (halt_op)
            pd_flag <= 1'b1;
         else if (clrwdt_op)
            pd_flag <= 1'b0;

         if (wdt_expire)
            to_flag <= 1'b1;
         else if (halt_op || clrwdt_op)
            to_flag <= 1'b0;
      end
   end

endmodule

// File: rtl/stat_flag_reg.sv
module stat_flag_reg
   import stat_flag_pkg::*;
#(
   parameter int unsigned DATA_W        = 8,
   parameter bit          OV_FROM_SIGNS = 1'b0
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic [2:0]        op_kind,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] result,
   input  logic              flag_en,
   input  logic              sw_wr,
   input  logic [7:0]        sw_data,
   input  logic              wdt_expire,
   input  logic              clrwdt_op,
   input  logic              halt_op,
   output logic [7:0]        status
);

   localparam int unsigned RSV_W = STATUS_W - BIT_TO - 1;

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_width
         $error("stat_flag_reg: DATA_W must be even and at least 4");
      end
   endgenerate

   arith_flags_t flags_q;
   arith_flags_t flags_nxt;
   arith_flags_t flags_mask;
   arith_flags_t flags_wr;
   logic         pd_flag;
   logic         to_flag;

   stat_flag_arith #(
      .DATA_W        (DATA_W),
      .OV_FROM_SIGNS (OV_FROM_SIGNS)
   ) u_arith (
      .op_kind    (op_kind),
      .op_a       (op_a),
      .op_b       (op_b),
      .carry_in   (carry_in),
      .result     (result),
      .flags_nxt  (flags_nxt),
      .flags_mask (flags_mask)
   );

   stat_flag_power u_power (
      .clk        (clk),
      .por_n      (por_n),
      .wdt_expire (wdt_expire),
      .clrwdt_op  (clrwdt_op),
      .halt_op    (halt_op),
      .pd_flag    (pd_flag),
      .to_flag    (to_flag)
   );

   always_comb begin
      flags_wr.c  = sw_data[BIT_C];
      flags_wr.ac = sw_data[BIT_AC];
      flags_wr.z  = sw_data[BIT_Z];
      flags_wr.ov = sw_data[BIT_OV];
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)
         flags_q <= '0;
      else if (sw_wr)
         flags_q <= flags_wr;
      else if (flag_en)
         flags_q <= (flags_nxt & flags_mask) | (flags_q & ~flags_mask);
   end

   always_comb begin
      status         = '0;
      status[BIT_C]  = flags_q.c;
      status[BIT_AC] = flags_q.ac;
      status[BIT_Z]  = flags_q.z;
      status[BIT_OV] = flags_q.ov;
      status[BIT_PD] = pd_flag;
      status[BIT_TO] = to_flag;
      status[STATUS_W-1 -: RSV_W] = '0;
   end

endmodule

// File: rtl/stat_flag_reg_chk.sv
module stat_flag_reg_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              por_n,
   input logic [2:0]        op_kind,
   input logic              flag_en,
   input logic              sw_wr,
   input logic [7:0]        sw_data,
   input logic              wdt_expire,
   input logic              clrwdt_op,
   input logic              halt_op,
   input logic [7:0]        status
);

   assert_rsv_zero_R12: assert property (@(posedge clk) disable iff (!por_n)
      status[7:6] == 2'b00);

   assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!por_n)
      (!flag_en && !sw_wr) |=> status[3:0] == $past(status[3:0]));

   assert_sw_load_R9: assert property (@(posedge clk) disable iff (!por_n)
      sw_wr |=> status[3:0] == $past(sw_data[3:0]));

   assert_logic_keep_R6: assert property (@(posedge clk) disable iff (!por_n)
      (flag_en && !sw_wr && op_kind == 3'd2)
      |=> (status[0] == $past(status[0]) && status[1] == $past(status[1])
           && status[3] == $past(status[3])));

   assert_halt_pd_R10: assert property (@(posedge clk) disable iff (!por_n)
      halt_op |=> status[4]);

   assert_clr_pd_R10: assert property (@(posedge clk) disable iff (!por_n)
      (clrwdt_op && !halt_op) |=> !status[4]);

   assert_wdt_to_R11: assert property (@(posedge clk) disable iff (!por_n)
      wdt_expire |=> status[5]);

   assert_clr_to_R11: assert property (@(posedge clk) disable iff (!por_n)
      ((clrwdt_op || halt_op) && !wdt_expire) |=> !status[5]);

   assert_pwr_keep_R11: assert property (@(posedge clk) disable iff (!por_n)
      (!wdt_expire && !clrwdt_op && !halt_op) |=> $stable(status[5:4]));

endmodule

bind stat_flag_reg stat_flag_reg_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .por_n      (por_n),
   .op_kind    (op_kind),
   .flag_en    (flag_en),
   .sw_wr      (sw_wr),
   .sw_data    (sw_data),
   .wdt_expire (wdt_expire),
   .clrwdt_op  (clrwdt_op),
   .halt_op    (halt_op),
   .status     (status)
);

// File: tb/stat_flag_reg_tb_top.sv
module stat_flag_reg_tb_top;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       por_n;
   logic [2:0] op_kind;
   logic [7:0] op_a, op_b, result, sw_data;
   logic       carry_in, flag_en, sw_wr, wdt_expire, clrwdt_op, halt_op;
   logic [7:0] status;

   int checks = 0;
   int fails  = 0;
   int exp_st = 0;

   stat_flag_reg dut_i (
      .clk(clk), .por_n(por_n), .op_kind(op_kind), .op_a(op_a), .op_b(op_b),
      .carry_in(carry_in), .result(result), .flag_en(flag_en), .sw_wr(sw_wr),
      .sw_data(sw_data), .wdt_expire(wdt_expire), .clrwdt_op(clrwdt_op),
      .halt_op(halt_op), .status(status)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int sgn(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   // Behavioural model of the next status value
   function automatic int model_next(input int cur);
      int a = op_a, b = op_b, ci = carry_in, bor, s;
      int c  = cur % 2;
      int ac = (cur / 2) % 2;
      int z  = (cur / 4) % 2;
      int ov = (cur / 8) % 2;
      int pd = (cur / 16) % 2;
      int to = (cur / 32) % 2;
      if (sw_wr) begin
         c = sw_data[0]; ac = sw_data[1]; z = sw_data[2]; ov = sw_data[3];
      end else if (flag_en) begin
         case (op_kind)
            3'd0: begin
               c  = (a + b + ci > 255) ? 1 : 0;
               ac = ((a % 16) + (b % 16) + ci > 15) ? 1 : 0;
               s  = sgn(a) + sgn(b) + ci;
               ov = (s > 127 || s < -128) ? 1 : 0;
               z  = (result == 0) ? 1 : 0;
            end
            3'd1: begin
               bor = 1 - ci;
               c  = (a >= b + bor) ? 1 : 0;
               ac = ((a % 16) >= (b % 16) + bor) ? 1 : 0;
               s  = sgn(a) - sgn(b) - bor;
               ov = (s > 127 || s < -128) ? 1 : 0;
               z  = (result == 0) ? 1 : 0;
            end
            3'd2: z = (result == 0) ? 1 : 0;
            3'd3: c = a / 128;
            3'd4: c = a % 2;
            default: ;
         endcase
      end
      if (halt_op) pd = 1;
      else if (clrwdt_op) pd = 0;
      if (wdt_expire) to = 1;
      else if (halt_op || clrwdt_op) to = 0;
      return c + 2*ac + 4*z + 8*ov + 16*pd + 32*to;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (status !== 8'(exp_st)) begin
         fails++;
         $display("FAIL %s status actual=%02h expected=%02h at %0t",
                  tag, status, 8'(exp_st), $time);
      end
   endtask

   task automatic idle_inputs();
      op_kind = 3'd7; op_a = 0; op_b = 0; result = 8'hFF; carry_in = 0;
      flag_en = 0; sw_wr = 0; sw_data = 0;
      wdt_expire = 0; clrwdt_op = 0; halt_op = 0;
   endtask

   // Inputs are already driven; advance one clock and compare
   task automatic step(input string tag);
      int nxt;
      nxt = model_next(exp_st);
      @(posedge clk);
      @(negedge clk);
      exp_st = nxt;
      check(tag);
   endtask

   task automatic alu(input int k, input int a, input int b, input int ci,
                      input string tag);
      idle_inputs();
      op_kind = 3'(k); op_a = 8'(a); op_b = 8'(b); carry_in = ci[0];
      flag_en = 1;
      if (k == 0)      result = 8'(a + b + ci);
      else if (k == 1) result = 8'(a - b - (1 - ci));
      else             result = 8'(a & b);
      step(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired, actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      idle_inputs();
      por_n = 0;
      repeat (3) @(negedge clk);
      exp_st = 0;
      check("R1 reset");
      por_n = 1;
      @(negedge clk);
      check("R1 after release");

      // R2 add corners
      alu(0, 8'hFF, 8'h01, 0, "R2 add wrap");
      alu(0, 8'h0F, 8'h01, 0, "R2 nibble carry");
      alu(0, 8'h10, 8'h20, 1, "R2 carry_in");
      // R3 subtract polarity
      alu(1, 5, 5, 1, "R3 equal no borrow");
      alu(1, 3, 5, 1, "R3 borrow");
      alu(1, 8'h10, 8'h01, 1, "R3 nibble borrow");
      alu(1, 5, 5, 0, "R3 borrow in");
      // R4 overflow
      alu(0, 8'h7F, 8'h01, 0, "R4 pos overflow");
      alu(1, 8'h80, 8'h01, 1, "R4 neg overflow");
      alu(0, 8'h80, 8'h80, 0, "R4 neg add");
      // R5 / R6 logic
      alu(0, 8'hFF, 8'hFF, 1, "R5 setup flags");
      alu(2, 8'hF0, 8'h0F, 0, "R5 R6 logic zero");
      alu(2, 8'hF0, 8'hFF, 0, "R5 R6 logic nonzero");
      // R7 rotates
      alu(3, 8'h80, 0, 0, "R7 rlc msb");
      alu(4, 8'h02, 0, 0, "R7 rrc lsb");
      alu(4, 8'h01, 0, 0, "R7 rrc set");
      // R8 hold and unused codes
      idle_inputs(); op_kind = 3'd0; op_a = 8'hFF; op_b = 8'h01; result = 0;
      step("R8 no enable");
      idle_inputs(); op_kind = 3'd6; flag_en = 1; result = 0;
      step("R8 unused code");
      // R9 write, precedence over ALU, upper bits ignored
      idle_inputs(); sw_wr = 1; sw_data = 8'hFA;
      step("R9 write upper ignored");
      idle_inputs(); sw_wr = 1; sw_data = 8'h05; flag_en = 1; op_kind = 3'd0;
      op_a = 8'h7F; op_b = 8'h01; result = 8'h80;
      step("R9 write beats alu");
      // R10 / R11 power flags and collisions
      idle_inputs(); halt_op = 1; step("R10 halt sets pd");
      idle_inputs(); wdt_expire = 1; step("R11 wdt sets to");
      idle_inputs(); sw_wr = 1; sw_data = 8'h00; step("R10 R11 write ignored");
      idle_inputs(); wdt_expire = 1; halt_op = 1; step("R11 wdt beats halt");
      idle_inputs(); clrwdt_op = 1; step("R10 R11 clear");
      idle_inputs(); wdt_expire = 1; clrwdt_op = 1; step("R11 wdt beats clear");
      idle_inputs(); halt_op = 1; clrwdt_op = 1; step("R10 halt beats clear");
      idle_inputs(); halt_op = 1; step("R11 halt clears to");

      // Mixed random traffic, model compared every clock (R12 each time)
      for (int i = 0; i < 3000; i++) begin
         int k;
         idle_inputs();
         k = $urandom_range(0, 6);
         op_kind = 3'(k);
         op_a = 8'($urandom); op_b = 8'($urandom);
         carry_in = 1'($urandom);
         if (k == 0)      result = op_a + op_b + 8'(carry_in);
         else if (k == 1) result = op_a - op_b - 8'(!carry_in);
         else             result = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
         flag_en    = ($urandom_range(0, 4) != 0);
         sw_wr      = ($urandom_range(0, 9) == 0);
         sw_data    = 8'($urandom);
         wdt_expire = ($urandom_range(0, 7) == 0);
         clrwdt_op  = ($urandom_range(0, 7) == 0);
         halt_op    = ($urandom_range(0, 7) == 0);
         step("R12 mixed");
      end

      idle_inputs();
      por_n = 0;
      #1;
      exp_st = 0;
      check("R1 async reset");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule